// File: doc/BRIEF.md
# Register-Controlled Single-Channel PWM Timer

This block produces one pulse-width-modulated output from a free-running tick counter. Software programs it over a small 32-bit register port with a 2-bit word index. Four words are exposed: the live count, the cycle length (period), the active-portion length (duty), and a control word. The period and the duty are counted in ticks. A tick comes from a fixed integer divider on the input clock, set by the `PRESCALE` parameter.

While it runs, the output holds a programmable active level from count zero until the count reaches the duty value. It then drives the opposite level until the cycle ends. In continuous mode the count wraps and the waveform repeats. In single-cycle mode the counter halts after one cycle and the output falls back to the idle level. The idle level is a separate control bit and applies whenever the channel is not running. After changing period or duty, software writes the count word (normally with 0) to start a fresh cycle from a known point.

Top module: `pwm_timer`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0 and `pwm_o` is low.
- R2: Word index 0 selects the count, 1 the period, 2 the duty and 3 the control word. `rdata_o` shows the selected word in the same cycle. A write takes effect at the next rising clock edge. Control keeps only bits 0, 1, 3, 4 and 5, so it reads back as the written value ANDed with 0x3B.
- R3: While running, the count advances once every `PRESCALE` clock cycles.
- R4: While running, `pwm_o` equals control bit 3 (duty level) when count < duty, and equals its inverse otherwise.
- R5: When duty ≥ period, `pwm_o` stays at the duty level for the whole cycle. When duty is 0, it stays at the opposite level.
- R6: When control bit 0 (enable) is 0, `pwm_o` equals control bit 4 (idle level) and the count does not change, except through a write to the count word.
- R7: With control bit 1 (continuous) set, an advance from count c with c+1 ≥ period sets the count to 0, and running goes on. A period of 0 or 1 therefore holds the count at 0.
- R8: With control bit 1 clear, the advance that ends a cycle sets the count to 0 and halts the channel. `pwm_o` then shows the idle level until the count word is written or enable is cleared.
- R9: A write to the count word loads that value and restarts the tick divider. The first advance after the load comes `PRESCALE` clock edges after the load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe for the selected word |
| addr_i | input | 2 | Word index: 0 count, 1 period, 2 duty, 3 control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word (combinational) |
| pwm_o | output | 1 | PWM output |

## Verification
A write lands at the rising edge where `we_i` is sampled. Register readback and `pwm_o` reflect the new state right after that edge, because the output level is decoded combinationally from registered state. The count first moves `PRESCALE` edges after a load. A single-cycle run halts on the edge that would wrap.

The bench drives inputs just after each falling edge and samples at the falling edge. It compares against a tick-level model updated on the same rising edges. This means every result is checked in the half cycle where it first becomes due. The directed checks wait exact edge counts, worked out from the divider and the period, before they read the count.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CTRL_W = 6;

  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_CONT    = 1;
  localparam int unsigned CB_DUTY_HI = 3;
  localparam int unsigned CB_IDLE_HI = 4;
  localparam int unsigned CB_ALIGN   = 5;

  localparam logic [CTRL_W-1:0] CTRL_MASK = 6'b111011;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_PER  = 2'd1,
    REG_DUTY = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] period_o,
  output logic [DATA_W-1:0] duty_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              cnt_load_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  logic [DATA_W-1:0] period_q, duty_q;
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      duty_q   <= '0;
      ctrl_q   <= '0;
    end else if (we_i) begin
      unique case (sel)
        REG_PER:  period_q <= wdata_i;
        REG_DUTY: duty_q   <= wdata_i;
        REG_CTRL: ctrl_q   <= wdata_i[CTRL_W-1:0] & CTRL_MASK;
        default: ;
      endcase
    end
  end

  assign cnt_load_o = we_i && (sel == REG_CNT);
  assign period_o   = period_q;
  assign duty_o     = duty_q;
  assign ctrl_o     = ctrl_q;

  always_comb begin
    unique case (sel)
      REG_CNT:  rdata_o = cnt_i;
      REG_PER:  rdata_o = period_q;
      REG_DUTY: rdata_o = duty_q;
      default:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    endcase
  end

  // R2: unimplemented control bits never read back as 1
  a_r2_ctrl_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == REG_CTRL) |-> ((rdata_o & ~DATA_W'(CTRL_MASK)) == '0));

  // R2: a write to the period word is visible after the edge
  a_r2_per_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == REG_PER) |=> (period_o == $past(wdata_i)));
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int unsigned PRESCALE = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  if (PRESCALE <= 1) begin : g_bypass
    assign tick_o = run_i;
  end else begin : g_div
    localparam int unsigned PW = $clog2(PRESCALE);
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
    logic [PW-1:0] pc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 pc_q <= '0;
      else if (restart_i || !run_i) pc_q <= '0;
      else if (pc_q == LAST)       pc_q <= '0;
      else                         pc_q <= pc_q + 1'b1;
    end

    assign tick_o = run_i && (pc_q == LAST);

    // R3: with a divider, two ticks never come on back-to-back edges
    a_r3_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);

    // R9: a restart puts the divider back at its first phase
    a_r9_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> !tick_o);
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cont_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W:0]   cnt_inc;
  logic             at_end;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign at_end  = cnt_inc >= {1'b0, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      done_q <= 1'b0;
    end else if (!en_i) begin
      done_q <= 1'b0;
    end else if (!done_q && tick_i) begin
      if (at_end) begin
        cnt_q <= '0;
        if (!cont_i) done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;

  // R6: disabled channel holds its count
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_o));

  // R7: end-of-cycle advance returns to zero
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !done_o && tick_i && !load_i && at_end) |=> (cnt_o == '0));

  // R8: halted counter stays at zero
  a_r8_halt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (cnt_o == '0));

  // R9: load value appears after the edge
  a_r9_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));
endmodule

// File: rtl/pwm_level.sv
module pwm_level #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             run_i,
  input  logic             duty_hi_i,
  input  logic             idle_hi_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic in_duty;
  assign in_duty = cnt_i < duty_i;

  always_comb begin
    if (!run_i)       pwm_o = idle_hi_i;
    else if (in_duty) pwm_o = duty_hi_i;
    else              pwm_o = !duty_hi_i;
  end
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PRESCALE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  logic [DATA_W-1:0] period, duty, cnt;
  logic [CTRL_W-1:0] ctrl;
  logic              cnt_load, tick, done, run;

  pwm_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .period_o   (period),
    .duty_o     (duty),
    .ctrl_o     (ctrl),
    .cnt_load_o (cnt_load),
    .rdata_o    (rdata_o)
  );

  assign run = ctrl[CB_EN] && !done;

  pwm_prescale #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (cnt_load),
    .tick_o    (tick)
  );

  pwm_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl[CB_EN]),
    .cont_i     (ctrl[CB_CONT]),
    .tick_i     (tick),
    .load_i     (cnt_load),
    .load_val_i (wdata_i),
    .period_i   (period),
    .cnt_o      (cnt),
    .done_o     (done)
  );

  pwm_level #(.CNT_W(DATA_W)) u_lvl (
    .run_i     (run),
    .duty_hi_i (ctrl[CB_DUTY_HI]),
    .idle_hi_i (ctrl[CB_IDLE_HI]),
    .cnt_i     (cnt),
    .duty_i    (duty),
    .pwm_o     (pwm_o)
  );

  // R6: disabled channel shows the idle level
  a_r6_idle_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[CB_EN] |-> (pwm_o == ctrl[CB_IDLE_HI]));

  // R8: halted single cycle shows the idle level
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> (pwm_o == ctrl[CB_IDLE_HI]));

  // R5: duty at or past period keeps the duty level while running
  a_r5_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && duty >= period && cnt < period) |-> (pwm_o == ctrl[CB_DUTY_HI]));
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 2;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer #(.PRESCALE(PRESC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // reference state, following the requirements
  logic [31:0] m_cnt, m_per, m_duty, m_ctrl;
  int          m_pc;
  logic        m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_per <= 0; m_duty <= 0; m_ctrl <= 0; m_pc <= 0; m_done <= 0;
    end else begin
      if (we && addr == 2'd1) m_per  <= wdata;
      if (we && addr == 2'd2) m_duty <= wdata;
      if (we && addr == 2'd3) m_ctrl <= wdata & 32'h3B;
      if (we && addr == 2'd0) begin
        m_cnt <= wdata; m_pc <= 0; m_done <= 0;
      end else if (!m_ctrl[0]) begin
        m_done <= 0; m_pc <= 0;
      end else if (m_done) begin
        m_pc <= 0;
      end else if (m_pc == PRESC - 1) begin
        m_pc <= 0;
        if (longint'(m_cnt) + 1 >= longint'(m_per)) begin
          m_cnt <= 0;
          if (!m_ctrl[1]) m_done <= 1;
        end else m_cnt <= m_cnt + 1;
      end else m_pc <= m_pc + 1;
    end
  end

  function automatic logic exp_pwm();
    if (!m_ctrl[0] || m_done) return m_ctrl[4];
    return (m_cnt < m_duty) ? m_ctrl[3] : !m_ctrl[3];
  endfunction

  function automatic string pwm_tag();
    if (!m_ctrl[0]) return "R6";
    if (m_done) return "R8";
    if (m_duty == 0 || m_duty >= m_per) return "R5";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison at every falling edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk(pwm_tag(), {31'b0, pwm}, {31'b0, exp_pwm()});
      if (!we && addr == 2'd0) chk("R3 count", rdata, m_cnt);
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 1'b0; addr = 2'd0; wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    #1 addr = 2'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int dummy;

  initial begin
    dummy = $urandom(32'd20240611);
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1: reset state
    chk("R1 pwm", {31'b0, pwm}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a); #1;
      chk("R1 reg", rdata, 32'h0);
    end
    addr = 2'd0;
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R2: readback and control mask
    wr(2'd3, 32'hFFFF_FFFE);
    rd_chk("R2 ctrl mask", 2'd3, 32'h3A);
    wr(2'd1, 32'h1234_5678);
    rd_chk("R2 period", 2'd1, 32'h1234_5678);
    wr(2'd2, 32'h0000_00A5);
    rd_chk("R2 duty", 2'd2, 32'h0000_00A5);

    // R6: disabled, idle high, count frozen
    wr(2'd0, 32'd7);
    idle(6);
    chk("R6 frozen", rdata, 32'd7);
    chk("R6 idle", {31'b0, pwm}, 32'd1);

    // R4/R9: continuous, duty high
    wr(2'd1, 32'd6);
    wr(2'd2, 32'd2);
    wr(2'd3, 32'h0B);
    wr(2'd0, 32'd3);
    idle(1);
    chk("R9 hold", rdata, 32'd3);
    idle(1);
    chk("R9 first", rdata, 32'd4);
    chk("R4 low", {31'b0, pwm}, 32'd0);
    idle(2);
    chk("R7 last", rdata, 32'd5);
    idle(2);
    chk("R7 wrap", rdata, 32'd0);
    chk("R4 high", {31'b0, pwm}, 32'd1);
    idle(30);

    // R4: inverted duty level, idle high
    wr(2'd3, 32'h13);
    idle(30);

    // R5: duty 0 and duty past period
    wr(2'd2, 32'd0);
    idle(20);
    wr(2'd2, 32'd9);
    idle(20);

    // R7: period 0 and 1 keep count at 0
    wr(2'd1, 32'd1);
    wr(2'd0, 32'd0);
    idle(8);
    chk("R7 per1", rdata, 32'd0);
    wr(2'd1, 32'd0);
    idle(8);
    chk("R7 per0", rdata, 32'd0);

    // R8: single cycle then halt
    wr(2'd1, 32'd4);
    wr(2'd2, 32'd2);
    wr(2'd3, 32'h09);
    wr(2'd0, 32'd0);
    idle(7);
    chk("R8 running", rdata, 32'd3);
    idle(2);
    chk("R8 halted", rdata, 32'd0);
    chk("R8 idle", {31'b0, pwm}, 32'd0);
    idle(10);
    chk("R8 stays", rdata, 32'd0);
    wr(2'd0, 32'd1);
    idle(1);
    chk("R8 restart", {31'b0, pwm}, 32'd1);
    idle(12);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int sel;
      logic [31:0] v;
      sel = int'($urandom % 4);
      case (sel)
        0: v = $urandom % 16;
        1: v = $urandom % 13;
        2: v = $urandom % 15;
        default: v = ($urandom & 32'hFF) | ((($urandom % 4) != 0) ? 32'h1 : 32'h0);
      endcase
      wr(2'(sel), v);
      idle(int'($urandom % 21));
    end

    summary();
    $finish;
  end
endmodule